// File: doc/BRIEF.md
# Read Data Error Checker

This block checks the read data that comes back while a memory test sequence is running. A small pattern store holds the expected data, one entry for each data vector. Software or the sequencer fills it through a plain write port. A comparison pointer, which is separate from the write address, selects the entry that each incoming read beat is checked against. After every beat the pointer moves on, and it returns to entry zero once it passes the last entry of the programmed pattern length. The pattern length is programmed as a code where length = (code + 1) * 8 entries.

The data path has nine byte lanes: eight data lanes and one check-code lane. Each bit that is not masked and differs from the expected value sets a sticky per-bit flag. A mismatch in a lane also sets that lane's sticky byte flag and increments its 16-bit counter. Any mismatch in a beat increments a global 16-bit counter and raises a one-cycle error pulse, which the sequencer's stop-on-error and trigger logic can use. The checker also keeps the index of the first failing data vector, and holds it until the counters are cleared. In breakpoint mode, the pointer and the vector index move only while the breakpoint input is high.

Top module: `rdata_err_checker`

## Requirements
- R1: After reset, every per-bit flag, byte flag, counter, first-error output and the error pulse is zero.
- R2: A beat on `rdValid` is compared with pattern entry `cmpPtr`. Lane L occupies bits [8L+7:8L], and lane 8 is the check-code lane. Every differing bit sets `bitErr` at the same position, and the result appears on the outputs one clock after the beat.
- R3: A bit is excluded from comparison when its `bitMask` bit is 1. Every bit of lane L is excluded when `laneMask[L]` is 1.
- R4: `bitErr` flags are sticky, and only `clrBitErr` clears them. `clrBitErr` leaves `byteErr` unchanged.
- R5: `byteErr[L]` is set by any unmasked mismatch in lane L. It is sticky, and only `clrByteErr` clears it.
- R6: Lane counter L (bits [16L+15:16L] of `laneErrCnt`) adds one for each beat in which lane L mismatches. `globalErrCnt` adds one for each beat that has any mismatch. Both stop at 0xFFFF, and `clrCnt` zeroes them.
- R7: The comparison pointer advances by one per beat. After entry `{patLenCode,3'b111}` it returns to 0. `cmpPtrLoad` sets it to `cmpPtrInit`.
- R8: When `bpMode` is 1, the pointer and the vector index advance only on beats where `bpActive` is 1. Beats are still checked while they are held.
- R9: The vector index counts advancing beats since reset or `clrCnt`. The first mismatching beat sets `firstErrValid` and captures that beat's index into `firstErrIdx`, and both stay frozen until `clrCnt`.
- R10: `errPulse` is high for exactly the one cycle that follows a beat with any unmasked mismatch.
- R11: When `clrCnt` arrives in the same cycle as a failing beat, the clear wins: the counters read 0 and `firstErrValid` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| patWrEn | input | 1 | Pattern store write enable |
| patWrAddr | input | 6 | Pattern store write address |
| patWrData | input | 72 | Pattern store write data |
| patLenCode | input | 3 | Pattern length code, length = (code+1)*8 |
| cmpPtrLoad | input | 1 | Load the comparison pointer |
| cmpPtrInit | input | 6 | Value loaded into the comparison pointer |
| bitMask | input | 72 | Per-bit compare exclusion |
| laneMask | input | 9 | Per-lane compare exclusion |
| bpMode | input | 1 | Advance only while the breakpoint input is high |
| bpActive | input | 1 | Breakpoint input |
| rdValid | input | 1 | Read beat strobe |
| rdData | input | 72 | Read beat data |
| clrBitErr | input | 1 | Clear the per-bit sticky flags |
| clrByteErr | input | 1 | Clear the per-lane sticky flags |
| clrCnt | input | 1 | Clear the counters, vector index and first-error capture |
| bitErr | output | 72 | Sticky per-bit error flags |
| byteErr | output | 9 | Sticky per-lane error flags |
| laneErrCnt | output | 144 | Nine saturating 16-bit lane counters |
| globalErrCnt | output | 16 | Saturating count of failing beats |
| firstErrValid | output | 1 | A first error has been captured |
| firstErrIdx | output | 16 | Vector index of the first error |
| errPulse | output | 1 | One-cycle pulse after a failing beat |

## Verification
Every result is registered at the clock edge that samples the beat. The flags, counters, first-error capture and error pulse are therefore due exactly one edge after the beat, and the pulse falls again at the edge after that. The bench drives each beat at a falling edge and drops `rdValid` at the next falling edge. It reads the outputs at that same falling edge, after the single register stage has updated and before the pulse falls. Clears use the same timing: a one-cycle strobe is applied, and the cleared value is read one edge later.

// File: rtl/rdchk_pkg.sv
package rdchk_pkg;
  localparam int unsigned LANE_W = 8;

  typedef struct packed {
    logic cmpEn;
    logic clrBit;
    logic clrByte;
    logic clrCnt;
  } rdchkStrobes_t;
endpackage

// File: rtl/rdchk_ctrl.sv
module rdchk_ctrl
  import rdchk_pkg::*;
#(
  parameter int unsigned PTR_W = 6,
  parameter int unsigned VEC_W = 16,
  localparam int unsigned LC_W = PTR_W - 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LC_W-1:0]  patLenCode,
  input  logic             cmpPtrLoad,
  input  logic [PTR_W-1:0] cmpPtrInit,
  input  logic             bpMode,
  input  logic             bpActive,
  input  logic             rdValid,
  input  logic             clrBitErr,
  input  logic             clrByteErr,
  input  logic             clrCnt,
  input  logic             anyErr,
  output logic [PTR_W-1:0] cmpPtr,
  output rdchkStrobes_t    strobes,
  output logic             firstErrValid,
  output logic [VEC_W-1:0] firstErrIdx
);
  logic             advance;
  logic [PTR_W-1:0] lastIdx;
  logic [VEC_W-1:0] vecCnt;

  assign advance = rdValid && (!bpMode || bpActive);
  assign lastIdx = {patLenCode, 3'b111};

  always_comb begin
    strobes.cmpEn   = rdValid;
    strobes.clrBit  = clrBitErr;
    strobes.clrByte = clrByteErr;
    strobes.clrCnt  = clrCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpPtr <= '0;
    end else if (cmpPtrLoad) begin
      cmpPtr <= cmpPtrInit;
    end else if (advance) begin
      cmpPtr <= (cmpPtr == lastIdx) ? '0 : cmpPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecCnt        <= '0;
      firstErrValid <= 1'b0;
      firstErrIdx   <= '0;
    end else if (clrCnt) begin
      vecCnt        <= '0;
      firstErrValid <= 1'b0;
      firstErrIdx   <= '0;
    end else begin
      if (advance) vecCnt <= vecCnt + 1'b1;
      if (rdValid && anyErr && !firstErrValid) begin
        firstErrValid <= 1'b1;
        firstErrIdx   <= vecCnt;
      end
    end
  end
endmodule

// File: rtl/rdchk_datapath.sv
module rdchk_datapath
  import rdchk_pkg::*;
#(
  parameter int unsigned NUM_LANES = 9,
  parameter int unsigned PTR_W     = 6,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned DATA_W   = NUM_LANES * LANE_W,
  localparam int unsigned DEPTH    = 1 << PTR_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       patWrEn,
  input  logic [PTR_W-1:0]           patWrAddr,
  input  logic [DATA_W-1:0]          patWrData,
  input  logic [PTR_W-1:0]           cmpPtr,
  input  rdchkStrobes_t              strobes,
  input  logic [DATA_W-1:0]          bitMask,
  input  logic [NUM_LANES-1:0]       laneMask,
  input  logic [DATA_W-1:0]          rdData,
  output logic                       anyErr,
  output logic [DATA_W-1:0]          bitErr,
  output logic [NUM_LANES-1:0]       byteErr,
  output logic [NUM_LANES*CNT_W-1:0] laneErrCnt,
  output logic [CNT_W-1:0]           globalErrCnt,
  output logic                       errPulse
);
  logic [DATA_W-1:0]    patMem [DEPTH];
  logic [DATA_W-1:0]    expData;
  logic [DATA_W-1:0]    laneBitEn;
  logic [DATA_W-1:0]    diff;
  logic [NUM_LANES-1:0] laneHit;

  always_ff @(posedge clk) begin
    if (patWrEn) patMem[patWrAddr] <= patWrData;
  end

  assign expData = patMem[cmpPtr];
  assign diff    = (rdData ^ expData) & ~bitMask & laneBitEn;
  assign anyErr  = |laneHit;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [CNT_W-1:0] cnt;

    assign laneBitEn[l*LANE_W +: LANE_W] = {LANE_W{~laneMask[l]}};
    assign laneHit[l] = |diff[l*LANE_W +: LANE_W];
    assign laneErrCnt[l*CNT_W +: CNT_W] = cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitErr[l*LANE_W +: LANE_W] <= '0;
      end else if (strobes.clrBit) begin
        bitErr[l*LANE_W +: LANE_W] <= '0;
      end else if (strobes.cmpEn) begin
        bitErr[l*LANE_W +: LANE_W] <= bitErr[l*LANE_W +: LANE_W] | diff[l*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        byteErr[l] <= 1'b0;
      end else if (strobes.clrByte) begin
        byteErr[l] <= 1'b0;
      end else if (strobes.cmpEn && laneHit[l]) begin
        byteErr[l] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (strobes.clrCnt) begin
        cnt <= '0;
      end else if (strobes.cmpEn && laneHit[l] && (cnt != '1)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalErrCnt <= '0;
      errPulse     <= 1'b0;
    end else begin
      errPulse <= strobes.cmpEn && anyErr;
      if (strobes.clrCnt) begin
        globalErrCnt <= '0;
      end else if (strobes.cmpEn && anyErr && (globalErrCnt != '1)) begin
        globalErrCnt <= globalErrCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdata_err_checker.sv
module rdata_err_checker
  import rdchk_pkg::*;
#(
  parameter int unsigned NUM_LANES = 9,
  parameter int unsigned PTR_W     = 6,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned VEC_W     = 16,
  localparam int unsigned DATA_W   = NUM_LANES * LANE_W,
  localparam int unsigned LC_W     = PTR_W - 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       patWrEn,
  input  logic [PTR_W-1:0]           patWrAddr,
  input  logic [DATA_W-1:0]          patWrData,
  input  logic [LC_W-1:0]            patLenCode,
  input  logic                       cmpPtrLoad,
  input  logic [PTR_W-1:0]           cmpPtrInit,
  input  logic [DATA_W-1:0]          bitMask,
  input  logic [NUM_LANES-1:0]       laneMask,
  input  logic                       bpMode,
  input  logic                       bpActive,
  input  logic                       rdValid,
  input  logic [DATA_W-1:0]          rdData,
  input  logic                       clrBitErr,
  input  logic                       clrByteErr,
  input  logic                       clrCnt,
  output logic [DATA_W-1:0]          bitErr,
  output logic [NUM_LANES-1:0]       byteErr,
  output logic [NUM_LANES*CNT_W-1:0] laneErrCnt,
  output logic [CNT_W-1:0]           globalErrCnt,
  output logic                       firstErrValid,
  output logic [VEC_W-1:0]           firstErrIdx,
  output logic                       errPulse
);
  logic [PTR_W-1:0] cmpPtr;
  rdchkStrobes_t    strobes;
  logic             anyErr;

  rdchk_ctrl #(.PTR_W(PTR_W), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .patLenCode(patLenCode),
    .cmpPtrLoad(cmpPtrLoad), .cmpPtrInit(cmpPtrInit),
    .bpMode(bpMode), .bpActive(bpActive), .rdValid(rdValid),
    .clrBitErr(clrBitErr), .clrByteErr(clrByteErr), .clrCnt(clrCnt),
    .anyErr(anyErr), .cmpPtr(cmpPtr), .strobes(strobes),
    .firstErrValid(firstErrValid), .firstErrIdx(firstErrIdx)
  );

  rdchk_datapath #(.NUM_LANES(NUM_LANES), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .patWrEn(patWrEn), .patWrAddr(patWrAddr),
    .patWrData(patWrData), .cmpPtr(cmpPtr), .strobes(strobes),
    .bitMask(bitMask), .laneMask(laneMask), .rdData(rdData),
    .anyErr(anyErr), .bitErr(bitErr), .byteErr(byteErr),
    .laneErrCnt(laneErrCnt), .globalErrCnt(globalErrCnt), .errPulse(errPulse)
  );
endmodule

// File: rtl/rdata_err_checker_sva.sv
module rdata_err_checker_sva #(
  parameter int unsigned DATA_W = 72,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned VEC_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdValid,
  input logic              clrBitErr,
  input logic              clrCnt,
  input logic [DATA_W-1:0] bitErr,
  input logic [CNT_W-1:0]  globalErrCnt,
  input logic              firstErrValid,
  input logic [VEC_W-1:0]  firstErrIdx,
  input logic              errPulse
);
  assert_pulse_after_beat_R10: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(rdValid));

  assert_pulse_counted_R10: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && !$past(clrCnt)) |-> (globalErrCnt != '0));

  assert_glob_no_decrease_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clrCnt) |-> (globalErrCnt >= $past(globalErrCnt)));

  assert_glob_idle_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!rdValid && !clrCnt) |=> $stable(globalErrCnt));

  assert_bit_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !clrBitErr |=> ((bitErr & $past(bitErr)) == $past(bitErr)));

  assert_first_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (firstErrValid && !clrCnt) |=> (firstErrValid && $stable(firstErrIdx)));

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    clrCnt |=> (globalErrCnt == '0 && !firstErrValid));
endmodule

bind rdata_err_checker rdata_err_checker_sva #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)
) u_sva (
  .clk(clk), .rstN(rstN), .rdValid(rdValid), .clrBitErr(clrBitErr),
  .clrCnt(clrCnt), .bitErr(bitErr), .globalErrCnt(globalErrCnt),
  .firstErrValid(firstErrValid), .firstErrIdx(firstErrIdx), .errPulse(errPulse)
);

// File: tb/rdata_err_checker_tb.sv
module rdata_err_checker_tb;
  localparam int NL = 9;
  localparam int DW = 72;
  localparam int PW = 6;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic patWrEn = 1'b0;
  logic [PW-1:0] patWrAddr = '0;
  logic [DW-1:0] patWrData = '0;
  logic [2:0] patLenCode = '0;
  logic cmpPtrLoad = 1'b0;
  logic [PW-1:0] cmpPtrInit = '0;
  logic [DW-1:0] bitMask = '0;
  logic [NL-1:0] laneMask = '0;
  logic bpMode = 1'b0, bpActive = 1'b0, rdValid = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic clrBitErr = 1'b0, clrByteErr = 1'b0, clrCnt = 1'b0;
  logic [DW-1:0] bitErr;
  logic [NL-1:0] byteErr;
  logic [NL*16-1:0] laneErrCnt;
  logic [15:0] globalErrCnt;
  logic firstErrValid;
  logic [15:0] firstErrIdx;
  logic errPulse;

  int nChecks = 0, nFails = 0, benchPtr = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rdata_err_checker u_dut (
    .clk(clk), .rstN(rstN), .patWrEn(patWrEn), .patWrAddr(patWrAddr),
    .patWrData(patWrData), .patLenCode(patLenCode), .cmpPtrLoad(cmpPtrLoad),
    .cmpPtrInit(cmpPtrInit), .bitMask(bitMask), .laneMask(laneMask),
    .bpMode(bpMode), .bpActive(bpActive), .rdValid(rdValid), .rdData(rdData),
    .clrBitErr(clrBitErr), .clrByteErr(clrByteErr), .clrCnt(clrCnt),
    .bitErr(bitErr), .byteErr(byteErr), .laneErrCnt(laneErrCnt),
    .globalErrCnt(globalErrCnt), .firstErrValid(firstErrValid),
    .firstErrIdx(firstErrIdx), .errPulse(errPulse)
  );

  // {flip[71:0], expected global count[15:0], expected byte flags[8:0]}
  localparam logic [96:0] TBL [9] = '{
    {72'h0,                  16'd0, 9'h000},
    {72'h1,                  16'd1, 9'h001},
    {72'h0,                  16'd1, 9'h001},
    {72'h800000000000000000, 16'd2, 9'h101},
    {72'h201000000,          16'd3, 9'h119},
    {72'h0,                  16'd3, 9'h119},
    {72'h80,                 16'd4, 9'h119},
    {72'h0,                  16'd4, 9'h119},
    {72'h0,                  16'd4, 9'h119}
  };

  function automatic logic [DW-1:0] pat(input int idx);
    logic [DW-1:0] v;
    for (int l = 0; l < NL; l++) v[l*8 +: 8] = 8'(idx * 37 + l * 11 + 8'h5A);
    return v;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [DW-1:0] flip);
    @(negedge clk);
    rdValid = 1'b1;
    rdData  = pat(benchPtr) ^ flip;
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic pulseClr(input int which);
    @(negedge clk);
    clrBitErr  = (which == 0);
    clrByteErr = (which == 1);
    clrCnt     = (which == 2);
    @(negedge clk);
    clrBitErr = 1'b0; clrByteErr = 1'b0; clrCnt = 1'b0;
  endtask

  task automatic loadPtr(input int p);
    @(negedge clk);
    cmpPtrLoad = 1'b1; cmpPtrInit = PW'(p);
    @(negedge clk);
    cmpPtrLoad = 1'b0;
    benchPtr = p;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] prevGlob;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 bitErr", bitErr, '0);
    check("R1 byteErr", 72'(byteErr), '0);
    check("R1 counters", 72'(laneErrCnt) | 72'(globalErrCnt), '0);
    check("R1 first/pulse", {firstErrIdx, firstErrValid, errPulse}, '0);

    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      patWrEn = 1'b1; patWrAddr = PW'(i); patWrData = pat(i);
    end
    @(negedge clk);
    patWrEn = 1'b0;

    // Table walk: R2 compare, R5 byte flags, R6 counting, R7 wrap, R10 pulse
    prevGlob = 16'd0;
    for (int t = 0; t < 9; t++) begin
      beat(TBL[t][96:25]);
      benchPtr = (benchPtr + 1) % 8;
      check("R6 table global count", 72'(globalErrCnt), 72'(TBL[t][24:9]));
      check("R5 table byte flags", 72'(byteErr), 72'(TBL[t][8:0]));
      check("R10 table pulse", 72'(errPulse), 72'(TBL[t][24:9] != prevGlob));
      prevGlob = TBL[t][24:9];
    end
    check("R2 bit flags", bitErr, 72'h800000000201000081);
    check("R6 lane0 count", 72'(laneErrCnt[15:0]), 72'd2);
    check("R9 first index", {firstErrIdx, firstErrValid}, {16'd1, 1'b1});

    // R3 masking
    bitMask[5] = 1'b1;
    beat(72'h20); benchPtr = (benchPtr + 1) % 8;
    check("R3 bit mask count", 72'(globalErrCnt), 72'd4);
    check("R3 bit mask flag", 72'(bitErr[5]), 72'd0);
    check("R3 bit mask pulse", 72'(errPulse), 72'd0);
    bitMask = '0; laneMask[2] = 1'b1;
    beat(72'h10000); benchPtr = (benchPtr + 1) % 8;
    check("R3 lane mask count", 72'(globalErrCnt), 72'd4);
    check("R3 lane mask flags", 72'(byteErr), 72'h119);
    laneMask = '0;

    // R4 / R5 separate clears
    pulseClr(0);
    check("R4 bit flags cleared", bitErr, '0);
    check("R4 byte flags kept", 72'(byteErr), 72'h119);
    pulseClr(1);
    check("R5 byte flags cleared", 72'(byteErr), '0);

    // R7 pointer load and longer pattern wrap
    loadPtr(5);
    beat('0); benchPtr = 6;
    check("R7 pointer load", 72'(globalErrCnt), 72'd4);
    patLenCode = 3'd1;
    loadPtr(15);
    beat('0); benchPtr = 0;
    beat('0); benchPtr = 1;
    check("R7 wrap at 16", 72'(globalErrCnt), 72'd4);

    pulseClr(2);
    check("R6 counters cleared", 72'(globalErrCnt) | 72'(laneErrCnt), '0);
    check("R9 first cleared", 72'(firstErrValid), 72'd0);

    // R8 breakpoint gating
    bpMode = 1'b1; bpActive = 1'b0;
    beat('0); beat('0);
    check("R8 held pointer", 72'(globalErrCnt), 72'd0);
    beat(72'h200);
    check("R8 held index", {firstErrIdx, firstErrValid}, {16'd0, 1'b1});
    bpActive = 1'b1;
    beat('0); benchPtr = 2;
    beat(72'h200); benchPtr = 3;
    check("R9 first frozen", {firstErrIdx, firstErrValid}, {16'd0, 1'b1});
    check("R6 lane1 count", 72'(laneErrCnt[31:16]), 72'd2);

    pulseClr(2);
    bpMode = 1'b0; bpActive = 1'b0;
    beat('0); benchPtr = 4;
    beat('0); benchPtr = 5;
    beat('0); benchPtr = 6;
    beat(72'h1); benchPtr = 7;
    check("R9 index after advances", {firstErrIdx, firstErrValid}, {16'd3, 1'b1});

    // R11 clear against simultaneous error
    @(negedge clk);
    rdValid = 1'b1; rdData = pat(benchPtr) ^ 72'h1; clrCnt = 1'b1;
    @(negedge clk);
    rdValid = 1'b0; clrCnt = 1'b0; benchPtr = 8;
    check("R11 global cleared", 72'(globalErrCnt), 72'd0);
    check("R11 first cleared", 72'(firstErrValid), 72'd0);
    check("R10 pulse with clear", 72'(errPulse), 72'd1);

    // R6 saturation, pointer held by breakpoint mode
    bpMode = 1'b1; bpActive = 1'b0;
    @(negedge clk);
    rdValid = 1'b1; rdData = pat(benchPtr) ^ 72'h1;
    repeat (65540) @(negedge clk);
    rdValid = 1'b0;
    check("R6 lane0 saturates", 72'(laneErrCnt[15:0]), 72'hFFFF);
    check("R6 global saturates", 72'(globalErrCnt), 72'hFFFF);
    check("R6 lane1 untouched", 72'(laneErrCnt[31:16]), 72'd0);
    @(negedge clk);
    check("R10 pulse falls", 72'(errPulse), 72'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule